// File: doc/BRIEF.md
# Tiled Convolution Stream Engine

This block computes one output tile of a convolution layer from two incoming streams. The first stream delivers a block of input features, one input channel per beat. The second stream delivers the matching block of weights, one output feature per beat. After a complete pair has arrived, the engine multiplies and accumulates the pair into a Tm x Tc array of signed fixed-point accumulators. The arithmetic uses one accumulator row per cycle.

Every input beat carries two flags. The first flag marks the opening block of a tile. The second flag marks the closing block of a tile. The opening flag makes the accumulators start from zero, so the tile does not continue the previous sum. After the closing block has been computed, the engine sends the whole tile on a third stream, one output feature per beat. While that output is pending, the engine refuses all new data. Upstream FIFOs feed the two input streams, and address generation is outside this block.

Top module: `conv_tile_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine returns to accepting input beats: after that edge `in_ready`=1, `wt_ready`=0 and `out_valid`=0.
- R2: An input block is exactly TN accepted beats. Beat n writes input channel n. Lane c of `in_data` is bits [c*DW +: DW]. After the TN-th beat, `in_ready` drops and `wt_ready` rises.
- R3: A weight block is exactly TM accepted beats. Beat m holds the weights of output feature m, and lane n of `wt_data` is bits [n*DW +: DW]. `in_ready` and `wt_ready` are never high together. Weight beats offered while `wt_ready`=0 are not taken.
- R4: For each block the engine computes acc[m][c] += sum over n of w[m][n]*x[n][c]. Operands are signed DW-bit values, and the accumulators are signed AW-bit values that wrap modulo 2^AW.
- R5: The flags of a block come from its final input beat. When `in_first`=1, each accumulator is replaced by the block's sum. When `in_first`=0, the sum is added to the value the accumulator already holds, including a value left over from an earlier tile.
- R6: The tile is emitted only after a block whose `in_last`=1. It goes out as exactly TM beats in the order m=0..TM-1, and lane c of `out_data` is bits [c*AW +: AW]. After a block with `in_last`=0, nothing is emitted and `in_ready` returns to 1.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_data` stays stable.
- R8: While `out_valid`=1, both `in_ready` and `wt_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input-feature beat offered |
| in_ready | output | 1 | Engine takes an input-feature beat |
| in_data | input | TC*DW | Tc signed values of one input channel |
| in_first | input | 1 | Opening block of a tile: start the accumulators from zero |
| in_last | input | 1 | Closing block of a tile: emit the tile after it |
| wt_valid | input | 1 | Weight beat offered |
| wt_ready | output | 1 | Engine takes a weight beat |
| wt_data | input | TN*DW | Tn signed weights of one output feature |
| out_valid | output | 1 | Output row available |
| out_ready | input | 1 | Consumer takes the output row |
| out_data | output | TC*AW | Tc accumulators of one output feature |

## Verification
The checker watches on every cycle that the two load readies never overlap and that no ready is raised during an emit. It also checks that a stalled output row holds still, that each input block is TN beats long, and that each emit is TM beats long. The reset state is checked in the same way. The arithmetic itself can only be shown by the bench's scenarios, which compare every emitted row with a reference model. These scenarios cover single-block tiles, multi-block tiles, a tile that continues the previous sum, extreme signed operands, output backpressure, and weight beats offered too early. The bench scenarios also show that a block without the closing flag produces no output.

// File: rtl/conv_tile_pkg.sv
// Package for the tiled convolution engine: phase encoding of the controller.
package conv_tile_pkg;
    typedef enum logic [1:0] {
        PH_LOAD_X = 2'd0,
        PH_LOAD_W = 2'd1,
        PH_CALC   = 2'd2,
        PH_EMIT   = 2'd3
    } phase_t;
endpackage

// File: rtl/conv_tile_ctrl.sv
// Controller of the tile engine.
// Sequences each block: TN input beats, then TM weight beats, then TM compute
// cycles (one accumulator row per cycle), then, if the block closed a tile,
// TM output beats. Assumes the flags of a block are constant or that the
// final beat carries the intended ones.
module conv_tile_ctrl
    import conv_tile_pkg::*;
#(
    parameter int TM = 16,
    parameter int TN = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic          in_last,
    input  logic          wt_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          wt_ready,
    output logic          out_valid,
    output logic          calc_en,
    output logic          clr_acc,
    output logic [CW-1:0] idx
);
    phase_t        phase;
    logic [CW-1:0] cnt;
    logic          first_q;
    logic          last_q;

    assign in_ready  = (phase == PH_LOAD_X);
    assign wt_ready  = (phase == PH_LOAD_W);
    assign out_valid = (phase == PH_EMIT);
    assign calc_en   = (phase == PH_CALC);
    assign clr_acc   = first_q;
    assign idx       = cnt;

    // Phase sequencing, beat/row counting and flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_LOAD_X;
            cnt     <= '0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            unique case (phase)
                PH_LOAD_X: if (in_valid) begin
                    first_q <= in_first;
                    last_q  <= in_last;
                    if (cnt == CW'(TN - 1)) begin
                        cnt   <= '0;
                        phase <= PH_LOAD_W;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOAD_W: if (wt_valid) begin
                    if (cnt == CW'(TM - 1)) begin
                        cnt   <= '0;
                        phase <= PH_CALC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CALC: begin
                    if (cnt == CW'(TM - 1)) begin
                        cnt   <= '0;
                        phase <= last_q ? PH_EMIT : PH_LOAD_X;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_EMIT: if (out_ready) begin
                    if (cnt == CW'(TM - 1)) begin
                        cnt   <= '0;
                        phase <= PH_LOAD_X;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_LOAD_X;
            endcase
        end
    end
endmodule

// File: rtl/conv_tile_buf.sv
// Register bank holding one block of a stream.
// ROWS rows of WIDTH bits. A row is written when wr_en is high and wr_idx
// selects it. All rows are visible at once on rd_flat (row r at r*WIDTH).
// Assumes wr_idx is below ROWS when wr_en is high.
module conv_tile_buf #(
    parameter int ROWS  = 8,
    parameter int WIDTH = 64,
    parameter int CW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CW-1:0]         wr_idx,
    input  logic [WIDTH-1:0]      wr_data,
    output logic [ROWS*WIDTH-1:0] rd_flat
);
    logic [WIDTH-1:0] mem [ROWS];

    // Capture the accepted beat into the row picked by the beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < ROWS; r++)
                if (wr_idx == CW'(r)) mem[r] <= wr_data;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_flat
        assign rd_flat[r*WIDTH +: WIDTH] = mem[r];
    end
endmodule

// File: rtl/conv_tile_mac.sv
// Accumulator array of TM x TC signed AW-bit sums.
// In each cycle with calc_en, the row selected by row_idx takes the TN-term dot
// product of the weight row and each input column. The result replaces the
// row (clr) or adds to it. The same row_idx selects the row shown on rd_row.
// Assumes operands are signed DW-bit and the sums wrap modulo 2^AW.
module conv_tile_mac #(
    parameter int TC = 4,
    parameter int TM = 16,
    parameter int TN = 8,
    parameter int DW = 16,
    parameter int AW = 40,
    parameter int CW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   calc_en,
    input  logic                   clr,
    input  logic [CW-1:0]          row_idx,
    input  logic [TN*TC*DW-1:0]    x_flat,
    input  logic [TM*TN*DW-1:0]    w_flat,
    output logic [TC*AW-1:0]       rd_row
);
    logic signed [AW-1:0] acc [TM][TC];
    logic [TN*DW-1:0]     w_sel;
    logic signed [AW-1:0] dot [TC];

    // Pick the weight row and the accumulator row addressed by row_idx.
    always_comb begin
        w_sel  = '0;
        rd_row = '0;
        for (int r = 0; r < TM; r++) begin
            if (row_idx == CW'(r)) begin
                w_sel = w_flat[r*TN*DW +: TN*DW];
                for (int c = 0; c < TC; c++) rd_row[c*AW +: AW] = acc[r][c];
            end
        end
    end

    for (genvar c = 0; c < TC; c++) begin : g_col
        // Signed dot product of the selected weight row with input column c.
        always_comb begin
            dot[c] = '0;
            for (int n = 0; n < TN; n++)
                dot[c] = dot[c] + AW'($signed(x_flat[(n*TC + c)*DW +: DW]) *
                                      $signed(w_sel[n*DW +: DW]));
        end
    end

    // Update one accumulator row per compute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < TM; r++)
                for (int c = 0; c < TC; c++) acc[r][c] <= '0;
        end else if (calc_en) begin
            for (int r = 0; r < TM; r++)
                if (row_idx == CW'(r))
                    for (int c = 0; c < TC; c++)
                        acc[r][c] <= (clr ? '0 : acc[r][c]) + dot[c];
        end
    end
endmodule

// File: rtl/conv_tile_engine.sv
// Top of the tiled convolution stream engine.
// Takes an input block (TN beats of TC values) and a weight block (TM beats of
// TN values) over ready/valid streams, then accumulates their product into a
// TM x TC tile. After a block flagged last, it emits the tile as TM beats.
// Assumes upstream FIFOs drive the two input streams.
module conv_tile_engine #(
    parameter int TC = 4,
    parameter int TM = 16,
    parameter int TN = 8,
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TC*DW-1:0] in_data,
    input  logic             in_first,
    input  logic             in_last,
    input  logic             wt_valid,
    output logic             wt_ready,
    input  logic [TN*DW-1:0] wt_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [TC*AW-1:0] out_data
);
    localparam int MAXR = (TM > TN) ? TM : TN;
    localparam int CW   = (MAXR > 1) ? $clog2(MAXR) : 1;

    logic                calc_en;
    logic                clr_acc;
    logic [CW-1:0]       idx;
    logic [TN*TC*DW-1:0] x_flat;
    logic [TM*TN*DW-1:0] w_flat;

    conv_tile_ctrl #(.TM(TM), .TN(TN), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .wt_valid(wt_valid), .out_ready(out_ready),
        .in_ready(in_ready), .wt_ready(wt_ready), .out_valid(out_valid),
        .calc_en(calc_en), .clr_acc(clr_acc), .idx(idx)
    );

    conv_tile_buf #(.ROWS(TN), .WIDTH(TC*DW), .CW(CW)) u_xbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(in_valid && in_ready), .wr_idx(idx), .wr_data(in_data),
        .rd_flat(x_flat)
    );

    conv_tile_buf #(.ROWS(TM), .WIDTH(TN*DW), .CW(CW)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wt_valid && wt_ready), .wr_idx(idx), .wr_data(wt_data),
        .rd_flat(w_flat)
    );

    conv_tile_mac #(.TC(TC), .TM(TM), .TN(TN), .DW(DW), .AW(AW), .CW(CW)) u_mac (
        .clk(clk), .rst_n(rst_n),
        .calc_en(calc_en), .clr(clr_acc), .row_idx(idx),
        .x_flat(x_flat), .w_flat(w_flat), .rd_row(out_data)
    );
endmodule

// File: rtl/conv_tile_engine_chk.sv
// Protocol checker for conv_tile_engine, attached by bind.
// Watches handshakes and readies only; holds two small beat counters.
module conv_tile_engine_chk #(
    parameter int TM = 16,
    parameter int TN = 8,
    parameter int AWD = 160
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           wt_valid,
    input logic           wt_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic [AWD-1:0] out_data
);
    int unsigned x_beats;
    int unsigned o_beats;

    // Count input beats of the current block and output beats of the current emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_beats <= 0;
            o_beats <= 0;
        end else begin
            if (wt_valid && wt_ready)      x_beats <= 0;
            else if (in_valid && in_ready) x_beats <= x_beats + 1;
            if (in_valid && in_ready)        o_beats <= 0;
            else if (out_valid && out_ready) o_beats <= o_beats + 1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !wt_ready && !out_valid));

    p_block_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wt_ready) |-> (x_beats == TN));

    p_ready_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && wt_ready));

    p_emit_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (o_beats == TM));

    p_emit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_no_accept_in_emit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!in_ready && !wt_ready));
endmodule

bind conv_tile_engine conv_tile_engine_chk #(.TM(TM), .TN(TN), .AWD(TC*AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .wt_valid(wt_valid), .wt_ready(wt_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/conv_tile_engine_bench.sv
// Directed bench for conv_tile_engine with a behavioural reference model.
module conv_tile_engine_bench;
    localparam int TC = 4;
    localparam int TM = 16;
    localparam int TN = 8;
    localparam int DW = 16;
    localparam int AW = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [TC*DW-1:0] in_data = '0;
    logic             in_first = 1'b0;
    logic             in_last = 1'b0;
    logic             wt_valid = 1'b0;
    logic             wt_ready;
    logic [TN*DW-1:0] wt_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [TC*AW-1:0] out_data;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    longint ref_acc [TM][TC];
    logic signed [DW-1:0] xv [TN][TC];
    logic signed [DW-1:0] wv [TM][TN];

    always #5 clk = ~clk;

    conv_tile_engine #(.TC(TC), .TM(TM), .TN(TN), .DW(DW), .AW(AW)) u_conv_tile_engine (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_data(wt_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fill operands: mode 0 small random, mode 1 extreme negatives.
    task automatic fill(input int mode);
        for (int n = 0; n < TN; n++)
            for (int c = 0; c < TC; c++)
                xv[n][c] = (mode == 1) ? DW'(-32768) : DW'(int'($urandom_range(0, 2000)) - 1000);
        for (int m = 0; m < TM; m++)
            for (int n = 0; n < TN; n++)
                wv[m][n] = (mode == 1) ? DW'(-32768 + m) : DW'(int'($urandom_range(0, 2000)) - 1000);
    endtask

    // Send one block (inputs then weights), update the model, check phase changes.
    task automatic send_block(input bit first, input bit last, input bit early_w);
        if (early_w) begin
            wt_valid = 1'b1;
            wt_data  = '1;
        end
        for (int n = 0; n < TN; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = first;
            in_last  = last;
            for (int c = 0; c < TC; c++) in_data[c*DW +: DW] = xv[n][c];
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        wt_valid = 1'b0;
        chk(!in_ready && wt_ready, "R2 after TN beats in_ready/wt_ready", {in_ready, wt_ready}, 1);
        for (int m = 0; m < TM; m++) begin
            if (m != 0) @(negedge clk);
            wt_valid = 1'b1;
            for (int n = 0; n < TN; n++) wt_data[n*DW +: DW] = wv[m][n];
            while (!wt_ready) @(negedge clk);
        end
        @(negedge clk);
        wt_valid = 1'b0;
        chk(!wt_ready && !in_ready, "R3 after TM weight beats", {in_ready, wt_ready}, 0);
        for (int m = 0; m < TM; m++)
            for (int c = 0; c < TC; c++) begin
                longint s = 0;
                for (int n = 0; n < TN; n++) s += longint'(wv[m][n]) * longint'(xv[n][c]);
                ref_acc[m][c] = first ? s : ref_acc[m][c] + s;
            end
        if (!last) begin
            bit seen = 1'b0;
            for (int k = 0; k < TM + 4; k++) begin
                @(negedge clk);
                if (out_valid) seen = 1'b1;
            end
            chk(!seen && in_ready, "R6 no emit after non-last block", {seen, in_ready}, 1);
        end
    endtask

    // Collect and compare TM output rows; optional stalls on out_ready.
    task automatic collect_tile(input bit stall, input string req);
        int m = 0;
        int cyc = 0;
        bit holding = 1'b0;
        logic [TC*AW-1:0] held = '0;
        while (m < TM) begin
            @(negedge clk);
            cyc++;
            if (holding) begin
                chk(out_valid && out_data == held, "R7 stalled row held", longint'(out_data[AW-1:0]), longint'(held[AW-1:0]));
                holding = 1'b0;
            end
            out_ready = stall ? (cyc % 3 == 0) : 1'b1;
            if (out_valid) begin
                if (m == 0) chk(!in_ready && !wt_ready, "R8 no ready during emit", {in_ready, wt_ready}, 0);
                if (out_ready) begin
                    bit ok = 1'b1;
                    longint a = 0, e = 0;
                    for (int c = 0; c < TC; c++)
                        if (ok && out_data[c*AW +: AW] !== ref_acc[m][c][AW-1:0]) begin
                            ok = 1'b0;
                            a = longint'($signed(out_data[c*AW +: AW]));
                            e = ref_acc[m][c];
                        end
                    chk(ok, req, a, e);
                    m++;
                end else begin
                    held = out_data;
                    holding = 1'b1;
                end
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && in_ready, "R6 exactly TM beats then accept input", {out_valid, in_ready}, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_ready && !wt_ready && !out_valid, "R1 reset state", {in_ready, wt_ready, out_valid}, 3'b100);
        rst_n = 1'b1;
    endtask

    task automatic t_single_block_tile();
        fill(0);
        send_block(1'b1, 1'b1, 1'b1);   // R3: early weight beats must be ignored
        collect_tile(1'b0, "R4 single-block tile row");
    endtask

    task automatic t_multi_block_tile();
        fill(0); send_block(1'b1, 1'b0, 1'b0);
        fill(0); send_block(1'b0, 1'b0, 1'b0);
        fill(0); send_block(1'b0, 1'b1, 1'b0);
        collect_tile(1'b1, "R4 three-block tile row with backpressure");
    endtask

    task automatic t_extreme_operands();
        fill(1); send_block(1'b1, 1'b0, 1'b0);
        fill(1); send_block(1'b0, 1'b1, 1'b0);
        collect_tile(1'b0, "R4 extreme signed operands row");
    endtask

    task automatic t_continue_sum();
        fill(0); send_block(1'b0, 1'b1, 1'b0);  // R5: continues previous tile's sums
        collect_tile(1'b0, "R5 no-first block adds to held sums");
    endtask

    task automatic t_restart_sum();
        fill(0); send_block(1'b1, 1'b1, 1'b0);  // R5: first flag drops old sums
        collect_tile(1'b1, "R5 first block restarts sums");
    endtask

    initial begin
        t_reset();
        t_single_block_tile();
        t_multi_block_tile();
        t_extreme_operands();
        t_continue_sum();
        t_restart_sum();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule